// File: doc/BRIEF.md
# Audio Clock Monitor and Recovery Sequencer

This block supervises the bit clock and frame clock that arrive at a slave serial audio port. Both are treated as data and sampled in the domain of a free-running, trusted internal oscillator. The block counts bit-clock rising edges between consecutive frame-clock rising edges and accepts only 32, 48 or 64 bit clocks per frame. A missing frame edge, any other count, or a change from the accepted ratio is a clock fault.

On a fault the block runs a fixed recovery sequence. It mutes at once, switches the PLL reference over to the oscillator, and waits for four consecutive frames that measure the same valid ratio. It then latches that ratio as the detected rate, hands the reference back to the master clock, and issues an unmute command. A configuration input chooses whether the unmute is a one-step restore of the default volume or a slow ramp. The PLL and the volume ramp sit outside this block, which only drives their command lines.

Top module: `audio_clk_monitor`

## Requirements
- R1: After reset, `clk_valid` is 0, `ratio` is 0, `ref_sel_osc` is 1, and `mute_req` and `unmute_req` are both 0.
- R2: A stable stream of 32, 48 or 64 bit-clock rising edges per frame leads to `clk_valid` = 1 with `ratio` = 1, 2 or 3 respectively.
- R3: Any other count per frame is a fault. In that case `clk_valid` stays 0 and `ratio` reads 0. `ratio` is 0 in every cycle in which `clk_valid` is 0.
- R4: When a fault is seen while `clk_valid` is 1, `clk_valid` falls. In the same cycle `mute_req` goes high for exactly one cycle. A fault that arrives while `clk_valid` is already 0 raises no `mute_req`.
- R5: `ref_sel_osc` (1 = oscillator, 0 = master clock) goes to 1 in the cycle after the mute request. It stays 1 until a rate has been detected, and it is 0 whenever `clk_valid` is 1.
- R6: Recovery needs four consecutive frames with the same valid ratio. Three such frames after the fault are not enough.
- R7: If no frame-clock rising edge arrives for `timeout_lim` oscillator cycles, the loss is treated as a fault.
- R8: Each recovery issues exactly one single-cycle `unmute_req`. `unmute_soft` equals `soft_unmute_en` during that pulse, where 1 means ramp and 0 means one-step restore. `clk_valid` is 1 in the cycle that follows.
- R9: A change from one accepted ratio to a different accepted ratio counts as a fault and runs the full sequence before the new ratio is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock, the timing reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Incoming bit clock, sampled as data |
| lrclk | input | 1 | Incoming frame clock, sampled as data |
| soft_unmute_en | input | 1 | 1 selects a ramped unmute, 0 a one-step unmute |
| timeout_lim | input | TO_W | Oscillator cycles without a frame edge before loss is declared |
| ratio | output | 2 | Detected ratio: 0 none, 1 = 32, 2 = 48, 3 = 64 |
| clk_valid | output | 1 | Clocks are valid and audio is live |
| ref_sel_osc | output | 1 | PLL reference select: 1 oscillator, 0 master clock |
| mute_req | output | 1 | Single-cycle instant-mute command |
| unmute_req | output | 1 | Single-cycle unmute command |
| unmute_soft | output | 1 | Unmute style, qualified by unmute_req |

## Verification
The assertions check the relations between the outputs in every cycle. They cover the following: `ratio` is zero whenever the clocks are invalid, and every drop of `clk_valid` coincides with a mute pulse. Each mute pulse lasts one cycle and is followed by oscillator reference selection. The reference is never the oscillator while the clocks are valid, and every unmute pulse leads into the valid state. Only the bench scenarios can show which ratio a given bit-clock count maps to, and that three matching frames are one too few. They also show that a silent frame clock trips the timeout and that faults arriving while already invalid stay silent.

// File: rtl/audio_clk_monitor.sv
module audio_clk_monitor #(
  parameter int CNT_W    = 8,
  parameter int TO_W     = 16,
  parameter int STABLE_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk,
  input  logic            lrclk,
  input  logic            soft_unmute_en,
  input  logic [TO_W-1:0] timeout_lim,
  output logic [1:0]      ratio,
  output logic            clk_valid,
  output logic            ref_sel_osc,
  output logic            mute_req,
  output logic            unmute_req,
  output logic            unmute_soft
);
  localparam int SW = $clog2(STABLE_N + 1);

  typedef enum logic [2:0] {S_NORMAL, S_MUTE, S_FALLBACK, S_WAIT, S_DETECT, S_UNMUTE} st_t;
  st_t st;

  logic [2:0]       bsync, lsync;
  logic [CNT_W-1:0] bcnt;
  logic [TO_W-1:0]  tcnt;
  logic             seen;
  logic [1:0]       cand, cur;
  logic [SW-1:0]    scnt;

  wire b_rise = bsync[1] & ~bsync[2];
  wire l_rise = lsync[1] & ~lsync[2];
  wire frame  = l_rise & seen;
  wire lost   = seen & ~l_rise & (tcnt == timeout_lim);

  wire [1:0] meas = (bcnt == CNT_W'(32)) ? 2'd1 :
                    (bcnt == CNT_W'(48)) ? 2'd2 :
                    (bcnt == CNT_W'(64)) ? 2'd3 : 2'd0;

  wire match  = frame & (meas != 2'd0) & (meas == cand);
  wire fault  = (frame & (meas != cur)) | lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsync <= '0;
      lsync <= '0;
      bcnt  <= '0;
      tcnt  <= '0;
      seen  <= 1'b0;
    end else begin
      bsync <= {bsync[1:0], bclk};
      lsync <= {lsync[1:0], lrclk};
      if (l_rise) begin
        bcnt <= CNT_W'(b_rise);
        tcnt <= '0;
        seen <= 1'b1;
      end else begin
        if (b_rise && bcnt != '1) bcnt <= bcnt + 1'b1;
        if (tcnt != timeout_lim)  tcnt <= tcnt + 1'b1;
        if (lost)                 seen <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cand <= 2'd0;
      cur  <= 2'd0;
      scnt <= '0;
    end else begin
      case (st)
        S_NORMAL:   if (fault) st <= S_MUTE;
        S_MUTE:     st <= S_FALLBACK;
        S_FALLBACK: begin
          cand <= 2'd0;
          scnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (lost) begin
            cand <= 2'd0;
            scnt <= '0;
          end else if (match) begin
            if (scnt == SW'(STABLE_N - 1)) st <= S_DETECT;
            else scnt <= scnt + 1'b1;
          end else if (frame) begin
            cand <= meas;
            scnt <= SW'(meas != 2'd0);
          end
        end
        S_DETECT: begin
          cur <= cand;
          st  <= S_UNMUTE;
        end
        S_UNMUTE:   st <= S_NORMAL;
        default:    st <= S_WAIT;
      endcase
    end
  end

  assign clk_valid   = (st == S_NORMAL);
  assign ratio       = clk_valid ? cur : 2'd0;
  assign ref_sel_osc = (st == S_FALLBACK) || (st == S_WAIT);
  assign mute_req    = (st == S_MUTE);
  assign unmute_req  = (st == S_UNMUTE);
  assign unmute_soft = unmute_req & soft_unmute_en;
endmodule

// File: rtl/audio_clk_monitor_chk.sv
module audio_clk_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ratio,
  input logic       clk_valid,
  input logic       ref_sel_osc,
  input logic       mute_req,
  input logic       unmute_req
);
  assert_ratio_zero_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_valid |-> ratio == 2'd0);

  assert_valid_has_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_valid |-> ratio != 2'd0);

  assert_drop_mutes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_valid) |-> mute_req);

  assert_mute_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> !mute_req);

  assert_fallback_after_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> ref_sel_osc);

  assert_master_when_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_valid |-> !ref_sel_osc);

  assert_unmute_to_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unmute_req |=> clk_valid && !unmute_req);
endmodule

bind audio_clk_monitor audio_clk_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ratio(ratio), .clk_valid(clk_valid),
  .ref_sel_osc(ref_sel_osc), .mute_req(mute_req), .unmute_req(unmute_req)
);

// File: tb/audio_clk_monitor_bench.sv
`timescale 1ns/1ps
module audio_clk_monitor_bench;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, lrclk = 1'b0, soft_en = 1'b0;
  logic [15:0] tlim = 16'd600;
  logic [1:0] ratio;
  logic clk_valid, ref_sel_osc, mute_req, unmute_req, unmute_soft;

  int tests = 0, fails = 0;
  int mute_tot = 0, unmute_tot = 0;
  logic last_soft = 1'b0;

  always #4 clk = ~clk;

  audio_clk_monitor u_audio_clk_monitor (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .soft_unmute_en(soft_en), .timeout_lim(tlim), .ratio(ratio),
    .clk_valid(clk_valid), .ref_sel_osc(ref_sel_osc), .mute_req(mute_req),
    .unmute_req(unmute_req), .unmute_soft(unmute_soft)
  );

  always @(negedge clk) begin
    if (mute_req) mute_tot <= mute_tot + 1;
    if (unmute_req) begin
      unmute_tot <= unmute_tot + 1;
      last_soft  <= unmute_soft;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lrclk = (i < n / 2);
      repeat (H) @(negedge clk);
      bclk = 1'b1;
      repeat (H) @(negedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic frames(input int n, input int k);
    for (int j = 0; j < k; j++) frame(n);
  endtask

  function automatic int code_of(input int n);
    return (n == 32) ? 1 : (n == 48) ? 2 : (n == 64) ? 3 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seq [14] = '{32, 48, 64, 31, 33, 40, 48, 47, 49, 63, 65, 16, 96, 64};
    int prev_code = 0;
    int m0, u0;
    repeat (3) @(negedge clk);
    check("R1 valid", clk_valid, 0);
    check("R1 ratio", ratio, 0);
    check("R1 ref_sel_osc", ref_sel_osc, 1);
    check("R1 mute_req", mute_req, 0);
    check("R1 unmute_req", unmute_req, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 14; s++) begin
      int c;
      c = code_of(seq[s]);
      soft_en = s[0];
      m0 = mute_tot; u0 = unmute_tot;
      frames(seq[s], 8);
      repeat (4) @(negedge clk);
      check(c != 0 ? "R2 valid" : "R3 invalid", clk_valid, c != 0);
      check(c != 0 ? "R2 ratio" : "R3 ratio", ratio, c);
      check((prev_code != 0 && c != prev_code) ? "R9 mute on change" : "R4 mute count",
            mute_tot - m0, (prev_code != 0 && c != prev_code) ? 1 : 0);
      check("R8 unmute count", unmute_tot - u0, (c != 0) ? 1 : 0);
      check("R5 ref select", ref_sel_osc, c == 0);
      if (c != 0) check("R8 unmute style", last_soft, s[0]);
      prev_code = c;
    end

    m0 = mute_tot;
    soft_en = 1'b1;
    frames(32, 5);
    @(negedge clk);
    check("R6 three frames not enough", clk_valid, 0);
    check("R6 ref held on osc", ref_sel_osc, 1);
    check("R9 single mute", mute_tot - m0, 1);
    frame(32);
    repeat (4) @(negedge clk);
    check("R6 fourth frame recovers", clk_valid, 1);
    check("R6 ratio", ratio, 1);
    check("R8 soft", last_soft, 1);

    m0 = mute_tot;
    bclk = 1'b0; lrclk = 1'b0;
    repeat (700) @(negedge clk);
    check("R7 loss invalid", clk_valid, 0);
    check("R7 loss mute", mute_tot - m0, 1);
    check("R7 loss ref osc", ref_sel_osc, 1);
    repeat (700) @(negedge clk);
    check("R4 no extra mute", mute_tot - m0, 1);
    soft_en = 1'b0;
    frames(48, 7);
    repeat (4) @(negedge clk);
    check("R7 relock valid", clk_valid, 1);
    check("R7 relock ratio", ratio, 2);
    check("R8 hard", last_soft, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule